// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides whether a received 29-bit CAN identifier is accepted, and by which filter. Two kinds of filter are checked side by side: a bank of receive message buffer filters and a small receive FIFO identifier table. Each filter is a 32-bit word. The incoming identifier is placed into a 32-bit word at a position that depends on the path, and is then compared with each filter word under a 32-bit acceptance mask.

A global mask serves every buffer filter and every FIFO table entry. Buffer filters 14 and 15 are the exception, because each has a mask of its own. On the buffer path the identifier sits one bit lower in the word than on the FIFO path. The mask works on word positions, not on identifier bits, so the same mask value leaves different identifier bits unchecked on the two paths.

The receive logic pulses a valid strobe with the identifier. Two cycles later the block returns a one-cycle done pulse. With it come a hit flag, a flag that says whether the FIFO table or a buffer won, and the index of the winning entry.

Top module: `can_rx_accept_filter`

## Requirements
- R1: Each cycle with `id_valid` high produces exactly one `done` pulse, one cycle wide, on the second rising edge after the strobe was sampled; `hit`, `hit_fifo` and `hit_idx` are valid in that cycle.
- R2: On the buffer path the received identifier occupies word bits 28..0 (identifier LSB at bit 0, bits 31..29 zero); with an all-ones mask a buffer matches only when its filter word equals that word.
- R3: On the FIFO path the received identifier occupies word bits 29..1 (bits 31..30 and bit 0 zero); with an all-ones mask an entry matches only when its filter word equals that word.
- R4: A filter matches when ((received_word XOR filter_word) AND mask) is zero: a mask bit of 0 makes that word bit don't-care, and a 1 requires equality.
- R5: With the global mask 0xFFFF_FFEF, buffer filtering ignores identifier bit 4 and FIFO filtering ignores identifier bit 3.
- R6: Buffers 14 and 15 use `mask_b14` and `mask_b15`, with the same word layout; every other buffer and every FIFO entry uses `glob_mask`.
- R7: FIFO table entries take part only while `fifo_en` is 1. A FIFO match takes priority over any buffer match, and `hit_fifo` = 1 marks it.
- R8: Among matching FIFO entries, and among matching enabled buffers, the lowest index wins and appears on `hit_idx`.
- R9: A buffer whose `mb_enable` bit is 0 never matches.
- R10: After reset, and in every cycle in which `done` is 0, `hit`, `hit_fifo` and `hit_idx` are 0.
- R11: When no filter matches, `done` still pulses, with `hit` = 0 and `hit_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | One-cycle strobe: `id_in` holds a new identifier |
| id_in | input | 29 | Received identifier |
| fifo_en | input | 1 | Include the FIFO table in filtering |
| glob_mask | input | 32 | Global acceptance mask |
| mask_b14 | input | 32 | Acceptance mask for buffer 14 |
| mask_b15 | input | 32 | Acceptance mask for buffer 15 |
| mb_enable | input | NUM_MB | Per-buffer receive-filter enable |
| mb_filters | input | NUM_MB*32 | Buffer filter words, buffer i at bits i*32+31..i*32 |
| fifo_filters | input | NUM_FIFO*32 | FIFO table words, entry j at bits j*32+31..j*32 |
| done | output | 1 | Result pulse |
| hit | output | 1 | An entry matched |
| hit_fifo | output | 1 | The winner is a FIFO table entry |
| hit_idx | output | IDX_W | Index of the winning entry |

## Verification
The bench walks a single cleared mask bit across all 32 word positions. At each position it flips every identifier bit in turn, on both paths, so a design that lined the identifier up the same way on both paths, or applied the mask to identifier bits, shows up as a wrong hit or a wrong miss at the shifted bit. Other scenes target a failed exception for buffers 14 and 15 (a stray match or a missing match on the masked low bits), a priority that lets a buffer beat a FIFO entry or a higher index beat a lower one, and a disabled buffer or a disabled FIFO table that still matches. A pseudo-random sweep over a mixed configuration, together with checks for the latency and for quiet outputs between results, catches off-by-one-cycle pulses.

// File: rtl/can_acc_pkg.sv
// Package: shared widths and identifier placement for the acceptance filter.
// Assumes a 32-bit filter word and a 29-bit extended identifier.
package can_acc_pkg;
    localparam int WORD_W      = 32;
    localparam int ID_W        = 29;
    localparam int MB_ID_LSB   = 0;  // buffer path: identifier in bits 28..0
    localparam int FIFO_ID_LSB = 1;  // FIFO path: identifier in bits 29..1

    // Put the identifier into a filter word, LSB at word bit lsb.
    function automatic logic [WORD_W-1:0] place_id(input logic [ID_W-1:0] id, input int lsb);
        return WORD_W'(id) << lsb;
    endfunction
endpackage

// File: rtl/can_acc_cmp.sv
// Module: one masked identifier comparator.
// Places the received identifier at ID_LSB and compares it with a filter word
// under a mask; a mask bit of 0 leaves that word position unchecked.
module can_acc_cmp
    import can_acc_pkg::*;
#(
    parameter int ID_LSB = 0
) (
    input  logic [ID_W-1:0]   id,
    input  logic [WORD_W-1:0] filter_word,
    input  logic [WORD_W-1:0] mask,
    output logic              match
);
    logic [WORD_W-1:0] rx_word;

    // Identifier placed at the word position this path uses.
    assign rx_word = place_id(id, ID_LSB);
    // Match when no bit the mask cares about differs.
    assign match   = ((rx_word ^ filter_word) & mask) == '0;
endmodule

// File: rtl/can_acc_prio.sv
// Module: lowest-index-first priority encoder.
// Assumes N >= 1 and that OUT_W can hold N-1.
module can_acc_prio #(
    parameter int N     = 16,
    parameter int OUT_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [OUT_W-1:0] idx
);
    // Scan from the top down so the lowest set request is the last one written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = OUT_W'(i);
            end
        end
    end

    // Checks that the winner asked for service and that no lower request was skipped.
    always_comb begin
        if (any) begin
            p_winner_requested_r8: assert (((req >> idx) & N'(1)) != '0);
            p_no_lower_request_r8: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
        end
    end
endmodule

// File: rtl/can_rx_accept_filter.sv
// Module: CAN receive acceptance filter (top).
// Stage 1 registers the per-filter match vectors for the buffer bank and the
// FIFO table. Stage 2 picks the winner (FIFO first, then the lowest index) and
// registers the result. Assumes the configuration inputs are steady around a
// strobe, since they are sampled on the edge that takes in id_valid.
module can_rx_accept_filter
    import can_acc_pkg::*;
#(
    parameter int NUM_MB   = 16,
    parameter int NUM_FIFO = 8,
    localparam int MAX_N   = (NUM_MB > NUM_FIFO) ? NUM_MB : NUM_FIFO,
    localparam int IDX_W   = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       id_valid,
    input  logic [ID_W-1:0]            id_in,
    input  logic                       fifo_en,
    input  logic [WORD_W-1:0]          glob_mask,
    input  logic [WORD_W-1:0]          mask_b14,
    input  logic [WORD_W-1:0]          mask_b15,
    input  logic [NUM_MB-1:0]          mb_enable,
    input  logic [NUM_MB*WORD_W-1:0]   mb_filters,
    input  logic [NUM_FIFO*WORD_W-1:0] fifo_filters,
    output logic                       done,
    output logic                       hit,
    output logic                       hit_fifo,
    output logic [IDX_W-1:0]           hit_idx
);
    logic [NUM_MB-1:0]   mb_match;
    logic [NUM_FIFO-1:0] fifo_match;
    logic [NUM_MB-1:0]   s1_mb_hits;
    logic [NUM_FIFO-1:0] s1_fifo_hits;
    logic                s1_valid;
    logic                s1_fifo_en;
    logic                mb_any;
    logic                fifo_any;
    logic [IDX_W-1:0]    mb_idx;
    logic [IDX_W-1:0]    fifo_idx;

    // Buffer comparators; buffers 14 and 15 take their own masks.
    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic [WORD_W-1:0] sel_mask;
        if (i == 14) begin : g_m14
            assign sel_mask = mask_b14;
        end else if (i == 15) begin : g_m15
            assign sel_mask = mask_b15;
        end else begin : g_mg
            assign sel_mask = glob_mask;
        end
        can_acc_cmp #(.ID_LSB(MB_ID_LSB)) u_cmp (
            .id          (id_in),
            .filter_word (mb_filters[i*WORD_W +: WORD_W]),
            .mask        (sel_mask),
            .match       (mb_match[i])
        );
    end

    // FIFO table comparators, all under the global mask.
    for (genvar j = 0; j < NUM_FIFO; j++) begin : g_fifo
        can_acc_cmp #(.ID_LSB(FIFO_ID_LSB)) u_cmp (
            .id          (id_in),
            .filter_word (fifo_filters[j*WORD_W +: WORD_W]),
            .mask        (glob_mask),
            .match       (fifo_match[j])
        );
    end

    // Stage 1: capture the match vectors, with disabled buffers removed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid     <= 1'b0;
            s1_fifo_en   <= 1'b0;
            s1_mb_hits   <= '0;
            s1_fifo_hits <= '0;
        end else begin
            s1_valid     <= id_valid;
            s1_fifo_en   <= fifo_en;
            s1_mb_hits   <= mb_match & mb_enable;
            s1_fifo_hits <= fifo_match;
        end
    end

    can_acc_prio #(.N(NUM_MB), .OUT_W(IDX_W)) u_mb_prio (
        .req (s1_mb_hits),
        .any (mb_any),
        .idx (mb_idx)
    );

    can_acc_prio #(.N(NUM_FIFO), .OUT_W(IDX_W)) u_fifo_prio (
        .req (s1_fifo_hits),
        .any (fifo_any),
        .idx (fifo_idx)
    );

    // Stage 2: register the result; the FIFO table beats the buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            hit      <= 1'b0;
            hit_fifo <= 1'b0;
            hit_idx  <= '0;
        end else begin
            done <= s1_valid;
            if (s1_valid && s1_fifo_en && fifo_any) begin
                hit      <= 1'b1;
                hit_fifo <= 1'b1;
                hit_idx  <= fifo_idx;
            end else if (s1_valid && mb_any) begin
                hit      <= 1'b1;
                hit_fifo <= 1'b0;
                hit_idx  <= mb_idx;
            end else begin
                hit      <= 1'b0;
                hit_fifo <= 1'b0;
                hit_idx  <= '0;
            end
        end
    end

    // A strobe always yields done two edges later.
    p_done_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> ##2 done);

    // Outputs stay quiet between results.
    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!hit && !hit_fifo && hit_idx == '0));

    // A FIFO win needs the table to have been enabled when it was sampled.
    p_fifo_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit_fifo) |-> $past(s1_fifo_en));

    // A buffer win names an existing buffer.
    p_mb_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit && !hit_fifo) |-> (int'(hit_idx) < NUM_MB));
endmodule

// File: tb/can_rx_accept_filter_tb_top.sv
module can_rx_accept_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NMB   = 16;
    localparam int NFF   = 8;
    localparam int IW    = 4;
    localparam int RES_W = 2 + IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid = 1'b0;
    logic [28:0] id_in = '0;
    logic fifo_en = 1'b0;
    logic [31:0] glob_mask = '1;
    logic [31:0] mask_b14 = '1;
    logic [31:0] mask_b15 = '1;
    logic [NMB-1:0] mb_enable = '0;
    logic [31:0] mb_flt [NMB];
    logic [31:0] ff_flt [NFF];
    logic [NMB*32-1:0] mb_filters;
    logic [NFF*32-1:0] fifo_filters;
    logic done, hit, hit_fifo;
    logic [IW-1:0] hit_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NMB; i++) mb_filters[i*32 +: 32] = mb_flt[i];
        for (int j = 0; j < NFF; j++) fifo_filters[j*32 +: 32] = ff_flt[j];
    end

    can_rx_accept_filter #(.NUM_MB(NMB), .NUM_FIFO(NFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_in(id_in),
        .fifo_en(fifo_en), .glob_mask(glob_mask), .mask_b14(mask_b14),
        .mask_b15(mask_b15), .mb_enable(mb_enable), .mb_filters(mb_filters),
        .fifo_filters(fifo_filters), .done(done), .hit(hit),
        .hit_fifo(hit_fifo), .hit_idx(hit_idx)
    );

    // Reference from the requirements: {hit, hit_fifo, idx}.
    function automatic logic [RES_W-1:0] model(input logic [28:0] id);
        logic [31:0] mbw = {3'b000, id};       // R2 placement
        logic [31:0] ffw = {2'b00, id, 1'b0};  // R3 placement
        if (fifo_en)
            for (int j = 0; j < NFF; j++)
                if (((ffw ^ ff_flt[j]) & glob_mask) == 0) return {1'b1, 1'b1, IW'(j)};
        for (int i = 0; i < NMB; i++) begin
            logic [31:0] m = (i == 14) ? mask_b14 : (i == 15) ? mask_b15 : glob_mask;
            if (mb_enable[i] && ((mbw ^ mb_flt[i]) & m) == 0) return {1'b1, 1'b0, IW'(i)};
        end
        return '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FIL FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Strobe one identifier, check quiet output and the result two edges later.
    task automatic query(input logic [28:0] id, input string tag);
        logic [RES_W-1:0] e;
        @(negedge clk);
        id_in = id; id_valid = 1'b1;
        @(negedge clk);
        id_valid = 1'b0;
        check({"R1/R10 quiet before result ", tag}, {28'd0, done, hit, hit_fifo, 1'b0}, 32'd0);
        @(negedge clk);
        e = model(id);
        check({"R1 done ", tag}, {31'd0, done}, 32'd1);
        check(tag, {26'd0, hit, hit_fifo, hit_idx}, {26'd0, e});
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < NMB; i++) mb_flt[i] = '0;
        for (int j = 0; j < NFF; j++) ff_flt[j] = '0;
        mb_enable = '0; fifo_en = 1'b0;
        glob_mask = '1; mask_b14 = '1; mask_b15 = '1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [28:0] base;
        logic [28:0] lfsr;
        clear_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset state", {28'd0, done, hit, hit_fifo, |hit_idx}, 32'd0);

        // R2: exact match for each buffer with all-ones masks.
        base = 29'h0ACE_1357;
        for (int i = 0; i < NMB; i++) mb_flt[i] = {3'b000, base ^ 29'(i * 29'h0101_0111)};
        mb_enable = '1;
        for (int i = 0; i < NMB; i++) query(base ^ 29'(i * 29'h0101_0111), "R2 buffer exact");
        query(base ^ 29'h1000_0000, "R11 no match");
        query(base ^ 29'h0000_0001, "R2 lsb differs");
        // R2: upper word bits are compared too.
        mb_flt[4] = {3'b100, base ^ 29'(4 * 29'h0101_0111)};
        query(base ^ 29'(4 * 29'h0101_0111), "R2 bit31 set in filter");

        // R8: duplicate filters, lowest wins; R9: disabling the winner.
        clear_cfg();
        mb_flt[3] = {3'b000, base}; mb_flt[9] = {3'b000, base};
        mb_enable = '1;
        query(base, "R8 lowest buffer wins");
        mb_enable[3] = 1'b0;
        query(base, "R9 disabled buffer skipped");
        mb_enable[9] = 1'b0;
        query(base, "R9 all disabled no hit");

        // R3/R7: FIFO placement, gating and priority.
        clear_cfg();
        ff_flt[2] = {2'b00, base, 1'b0};
        ff_flt[5] = {2'b00, base, 1'b0};
        mb_flt[0] = {3'b000, base}; mb_enable[0] = 1'b1;
        query(base, "R7 FIFO off buffer wins");
        fifo_en = 1'b1;
        query(base, "R7 FIFO beats buffer, R8 lowest entry");
        ff_flt[2] = {3'b000, base};
        query(base, "R3 buffer placement does not hit FIFO");

        // R5: the documented mask value on both paths.
        clear_cfg();
        glob_mask = 32'hFFFF_FFEF;
        mb_flt[2] = {3'b000, base}; mb_enable[2] = 1'b1;
        query(base ^ 29'h10, "R5 buffer ignores id bit 4");
        query(base ^ 29'h08, "R5 buffer checks id bit 3");
        mb_enable = '0; fifo_en = 1'b1;
        ff_flt[0] = {2'b00, base, 1'b0};
        query(base ^ 29'h08, "R5 FIFO ignores id bit 3");
        query(base ^ 29'h10, "R5 FIFO checks id bit 4");

        // R6: buffers 14 and 15 own masks.
        clear_cfg();
        mask_b14 = 32'hFFFF_FF00; mask_b15 = 32'hFFFF_0000;
        mb_flt[5] = {3'b000, base}; mb_flt[14] = {3'b000, base}; mb_flt[15] = {3'b000, base};
        mb_enable = '1;
        query(base ^ 29'h00FF, "R6 buffer 14 mask");
        query(base ^ 29'hFF00, "R6 buffer 15 mask");
        query(base, "R6 global buffer 5 first");
        glob_mask = 32'h0000_00FF;
        query(base ^ 29'h00FF, "R6 mask 14 not global");

        // R4: walk one cleared mask bit over every word position, both paths.
        for (int pth = 0; pth < 2; pth++) begin
            clear_cfg();
            if (pth == 0) begin
                mb_flt[0] = {3'b000, base}; mb_enable[0] = 1'b1;
            end else begin
                ff_flt[0] = {2'b00, base, 1'b0}; fifo_en = 1'b1;
            end
            for (int b = 0; b < 32; b++) begin
                glob_mask = ~(32'd1 << b);
                for (int k = 0; k < 29; k++) query(base ^ (29'd1 << k), "R4 walking mask");
            end
            glob_mask = '0;
            query(~base, "R4 zero mask accepts any");
        end

        // R8/R7 mixed configuration sweep.
        clear_cfg();
        lfsr = 29'h1BAD_F00D;
        glob_mask = 32'hFFFF_FFC3; mask_b14 = 32'hFFFF_FFF0; mask_b15 = 32'h1FFF_FF0F;
        for (int i = 0; i < NMB; i++) mb_flt[i] = {3'b000, base ^ 29'(i & 29'h7)};
        for (int j = 0; j < NFF; j++) ff_flt[j] = {2'b00, base ^ 29'(j * 3), 1'b0};
        mb_enable = 16'hB6DB;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[27:0], lfsr[28] ^ lfsr[26]};
            fifo_en = lfsr[7];
            query(base ^ (lfsr & 29'h0000_003F), "R8 mixed sweep");
        end

        @(negedge clk);
        check("R1 done single pulse", {31'd0, done}, 32'd0);
        finish_run();
    end
endmodule